// File: doc/BRIEF.md
# Isolation Channel Transition Pulse Encoder

This block is the transmit half of a group of unidirectional isolation channels. Each channel takes a logic level and turns it into two one-cycle strobes for the barrier driver. A "set" strobe marks a change from low to high, and a "clear" strobe marks a change from high to low. The receiver is a bistable latch that these strobes drive.

A channel can sit with a steady input for a long time. To keep the receiver from drifting, the channel restarts an idle timer on every real edge. Once the input has been quiet for the idle interval, it re-sends the present level as a set strobe (level high) or a clear strobe (level low). It then repeats that refresh at the refresh interval for as long as the input stays quiet. A receiver that stops seeing strobes can treat the transmitter as dead.

A side-power input gates the whole transmit side. While that input is low, nothing is sent. Every channel has its own synchronizer, edge detector and timer, so channels never affect one another. All times are counted in clock cycles and set through parameters.

Top module: `isoenc_pulse_tx`

## Requirements
- R1: While `rst` is sampled high at a clock edge, every `set_o` and `clr_o` bit is 0 after that edge, and all synchronizer stages are cleared to level 0.
- R2: When a channel's input rises and is sampled high at clock edge N, that channel's `set_o` bit is 1 for exactly one cycle, following edge N+2. This assumes the side is powered.
- R3: When a channel's input falls and is sampled low at clock edge N, that channel's `clr_o` bit is 1 for exactly one cycle, following edge N+2. This assumes the side is powered.
- R4: If no strobe has been sent since the last edge strobe or power restart, a refresh strobe is sent IDLE_CYCLES edges later. A high level sends it on `set_o` and a low level sends it on `clr_o`.
- R5: After a refresh strobe, and while the input stays quiet, further refresh strobes follow every REFRESH_CYCLES edges. Each one encodes the current level in the same way as R4.
- R6: An input edge restarts that channel's timer. Outside the strobes of R2 to R5, the outputs stay 0.
- R7: At any edge where `side_pwr_i` is sampled low, all outputs are 0 after that edge. The timer restarts, so the first refresh after power returns comes IDLE_CYCLES edges after the last unpowered edge.
- R8: A channel never asserts `set_o` and `clr_o` in the same cycle.
- R9: Each channel's strobes depend only on its own input bit, together with the shared reset and power inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| side_pwr_i | input | 1 | Transmit side powered; low suppresses all strobes |
| din_i | input | NUM_CH | Logic inputs, one bit per channel (asynchronous) |
| set_o | output | NUM_CH | One-cycle strobes meaning the level is high (edge or refresh) |
| clr_o | output | NUM_CH | One-cycle strobes meaning the level is low (edge or refresh) |

## Verification
The bench builds the block with five channels, IDLE_CYCLES of 12 and REFRESH_CYCLES of 8. These short intervals let a few thousand cycles cover many complete idle-then-refresh cycles on every channel. A sweep over hold widths from one cycle upward places input edges before, on and after each refresh slot. It also puts a different period on each channel, which exercises channel independence. Power drops, mid-run resets and a pseudo-random phase are checked cycle by cycle against an arithmetic model built from the requirements.

// File: rtl/isoenc_pkg.sv
package isoenc_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } strobe_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/isoenc_sync.sv
module isoenc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R1: synchronizer comes out of reset at level 0
  a_r1_sync_cleared: assert property (@(posedge clk) rst |=> (q == 1'b0));
endmodule

// File: rtl/isoenc_gap_timer.sv
module isoenc_gap_timer #(
  parameter int unsigned IDLE_CYCLES    = 100,
  parameter int unsigned REFRESH_CYCLES = 100,
  parameter int unsigned CW             = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic fire
);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYCLES - 1);
  localparam logic [CW-1:0] RFSH_LAST = CW'(REFRESH_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          in_refresh;
  logic [CW-1:0] last_val;

  assign last_val = in_refresh ? RFSH_LAST : IDLE_LAST;
  assign fire     = (cnt == last_val);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt        <= '0;
      in_refresh <= 1'b0;
    end else if (fire) begin
      cnt        <= '0;
      in_refresh <= 1'b1;
    end else begin
      cnt        <= cnt + 1'b1;
    end
  end

  // R6: a restart always brings the count back to zero in the idle phase
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !in_refresh));
  // R5: the count never passes the limit of its current phase
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (cnt <= last_val));
  // R4: once the first refresh fires, later ones use the refresh interval
  a_r4_phase_switch: assert property (@(posedge clk) disable iff (rst)
    (fire && !restart) |=> in_refresh);
endmodule

// File: rtl/isoenc_lane.sv
module isoenc_lane
  import isoenc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned IDLE_CYCLES    = 100,
  parameter int unsigned REFRESH_CYCLES = 100,
  parameter int unsigned CW             = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr,
  input  logic    din,
  output strobe_t out
);
  logic lvl;
  logic lvl_prev;
  logic edge_seen;
  logic rf_fire;
  logic send;

  isoenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (lvl)
  );

  assign edge_seen = (lvl != lvl_prev);

  isoenc_gap_timer #(
    .IDLE_CYCLES    (IDLE_CYCLES),
    .REFRESH_CYCLES (REFRESH_CYCLES),
    .CW             (CW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (edge_seen || !pwr),
    .fire    (rf_fire)
  );

  assign send = pwr && (edge_seen || rf_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= 1'b0;
      out      <= '0;
    end else begin
      lvl_prev <= lvl;
      out.set  <= send && lvl;
      out.clr  <= send && !lvl;
    end
  end

  // R8: never both strobes on one channel
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out.set && out.clr));
  // R7: unpowered side sends nothing
  a_r7_quiet_unpowered: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> (!out.set && !out.clr));
  // R2: a synchronized rise yields a set strobe
  a_r2_set_on_rise: assert property (@(posedge clk) disable iff (rst)
    (pwr && lvl && !lvl_prev) |=> out.set);
  // R3: a synchronized fall yields a clear strobe
  a_r3_clr_on_fall: assert property (@(posedge clk) disable iff (rst)
    (pwr && !lvl && lvl_prev) |=> out.clr);
endmodule

// File: rtl/isoenc_pulse_tx.sv
module isoenc_pulse_tx
  import isoenc_pkg::*;
#(
  parameter int unsigned NUM_CH         = 5,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned IDLE_CYCLES    = 100,
  parameter int unsigned REFRESH_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              side_pwr_i,
  input  logic [NUM_CH-1:0] din_i,
  output logic [NUM_CH-1:0] set_o,
  output logic [NUM_CH-1:0] clr_o
);
  localparam int unsigned CW = $clog2(max2(IDLE_CYCLES, REFRESH_CYCLES) + 1);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      strobe_t st;
      isoenc_lane #(
        .SYNC_STAGES    (SYNC_STAGES),
        .IDLE_CYCLES    (IDLE_CYCLES),
        .REFRESH_CYCLES (REFRESH_CYCLES),
        .CW             (CW)
      ) u_lane (
        .clk (clk),
        .rst (rst),
        .pwr (side_pwr_i),
        .din (din_i[c]),
        .out (st)
      );
      assign set_o[c] = st.set;
      assign clr_o[c] = st.clr;
    end
  endgenerate

  // R1: outputs idle after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (set_o == '0 && clr_o == '0));
  // R8: no channel shows both strobes at once
  a_r8_all_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((set_o & clr_o) == '0));
endmodule

// File: tb/tb_isoenc_pulse_tx.sv
module tb_isoenc_pulse_tx;
  localparam int NC = 5;
  localparam int ID = 12;
  localparam int RF = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr = 1'b1;
  logic [NC-1:0] din = '0;
  logic [NC-1:0] set_o, clr_o;

  always #10 clk = ~clk;

  isoenc_pulse_tx #(
    .NUM_CH(NC), .SYNC_STAGES(2), .IDLE_CYCLES(ID), .REFRESH_CYCLES(RF)
  ) dut (
    .clk(clk), .rst(rst), .side_pwr_i(pwr), .din_i(din),
    .set_o(set_o), .clr_o(clr_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  int    tcur     = 0;
  string phase    = "R1";

  logic [NC-1:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
  logic [NC-1:0] exp_set = '0, exp_clr = '0;
  int            last_t [NC];
  bit            in_rf  [NC];
  string         tag    [NC];

  // Model from requirements: level seen at edge N drives strobes after edge N+2.
  task automatic model_update();
    tcur++;
    if (rst) begin
      h0 = '0; h1 = '0; h2 = '0; h3 = '0;
      exp_set = '0; exp_clr = '0;
      for (int c = 0; c < NC; c++) begin
        last_t[c] = tcur; in_rf[c] = 0; tag[c] = "R1";
      end
    end else begin
      h3 = h2; h2 = h1; h1 = h0; h0 = din;
      exp_set = '0; exp_clr = '0;
      for (int c = 0; c < NC; c++) begin
        if (!pwr) begin
          last_t[c] = tcur; in_rf[c] = 0; tag[c] = "R7";
        end else if (h2[c] != h3[c]) begin
          exp_set[c] = h2[c]; exp_clr[c] = !h2[c];
          last_t[c] = tcur; in_rf[c] = 0;
          tag[c] = h2[c] ? "R2" : "R3";
        end else if (tcur - last_t[c] == (in_rf[c] ? RF : ID)) begin
          exp_set[c] = h2[c]; exp_clr[c] = !h2[c];
          tag[c] = in_rf[c] ? "R5" : "R4";
          last_t[c] = tcur; in_rf[c] = 1;
        end else begin
          tag[c] = "R6";
        end
      end
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NC; c++) begin
      n_checks++;
      if (set_o[c] !== exp_set[c] || clr_o[c] !== exp_clr[c]) begin
        n_fail++;
        $display("FAIL %s/%s ch%0d t=%0d: set/clr=%b%b expected %b%b",
                 tag[c], phase, c, tcur, set_o[c], clr_o[c], exp_set[c], exp_clr[c]);
      end
    end
    n_checks++;
    if ((set_o & clr_o) != '0) begin
      n_fail++;
      $display("FAIL R8 t=%0d: set&clr=%b expected 0", tcur, set_o & clr_o);
    end
  endtask

  task automatic step(input logic [NC-1:0] d, input logic p, input logic r);
    din = d; pwr = p; rst = r;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [NC-1:0] v;
    // R1: reset held, outputs must stay low
    phase = "R1";
    for (int i = 0; i < 4; i++) step('0, 1'b1, 1'b1);
    // R4 R5: quiet low level, refresh on clear strobes
    phase = "R4";
    for (int i = 0; i < 40; i++) step('0, 1'b1, 1'b0);
    // R2 R9: one channel rises, others keep refreshing low
    phase = "R9";
    for (int i = 0; i < 30; i++) step(5'b00001, 1'b1, 1'b0);
    // R3: it falls again
    phase = "R3";
    for (int i = 0; i < 30; i++) step(5'b00000, 1'b1, 1'b0);
    // R6 R9: width sweep, each channel with its own period
    phase = "R6";
    for (int w = 1; w <= 24; w++) begin
      for (int k = 0; k < 60; k++) begin
        for (int c = 0; c < NC; c++) v[c] = ((k / (w + c)) % 2) == 1;
        step(v, 1'b1, 1'b0);
      end
    end
    // R5: long quiet mixed levels
    phase = "R5";
    for (int i = 0; i < 60; i++) step(5'b10110, 1'b1, 1'b0);
    // R7: power drops while inputs toggle, then returns quiet
    phase = "R7";
    for (int i = 0; i < 30; i++) step(NC'(i * 7), 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step(NC'(29 * 7), 1'b1, 1'b0);
    // R1: reset mid-run with all inputs high
    phase = "R1";
    for (int i = 0; i < 3; i++) step('1, 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) step('1, 1'b1, 1'b0);
    // pseudo-random inputs and power
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[3:0] == 4'd0) ? lfsr[8:4] : din, (lfsr[15:11] != 5'd0) || pwr == 1'b0 && lfsr[0], 1'b0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule